// File: doc/BRIEF.md
# Per-Vector Interrupt Message Generator

This block turns interrupt requests into posted memory writes. It keeps one table row for each vector. A row holds a 64-bit target address, a 32-bit payload word and a mask flag, so different vectors can be aimed at different processors. Software reaches the rows and a read-only array of pending flags through a simple 32-bit register port. Reads are combinational and writes take effect on the clock edge.

An event source sends a vector number on the request port. If the function is enabled, the request marks that vector pending. A pending vector whose mask is clear is served when three conditions hold: the function-wide hold is released, no earlier data write from the device is still outstanding, and the output slot is free. Serving a vector emits one write, carrying that vector's address and payload, on a valid/ready message port. If several vectors are eligible, they are served in rotation.

The register space is split by the top address bit:
- With the top bit clear, the address is `vector*4 + word`. Word 0 is the low address half, word 1 the high address half, word 2 the payload, and word 3 the control word, whose bit 0 is the mask. The other control bits read 0.
- With the top bit set, the low bits pick a 32-bit pending word. Bit b of word w is vector 32*w+b.

Top module: `vec_msg_gen`

## Requirements
- R1: After reset every vector is masked (control word reads 1), its address and payload words read 0, every pending flag is 0, `msgValid` is 0 and `irqErr` is 0.
- R2: Register word `vector*4+k` (top address bit 0) reads back what was last written there: k=0 low address, k=1 high address, k=2 payload, k=3 control. Only bit 0 of the control word is stored, and the other control bits read 0.
- R3: A request for an unmasked vector, sampled at clock edge n with the function enabled and unheld, raises `msgValid` after edge n+1. The message has `msgAddr = {high, low}` and `msgData = payload` of that vector, and exactly one write is emitted.
- R4: A request for a masked vector emits nothing and sets its pending flag, which reads as bit b of pending word w (top address bit 1, low bits w) for vector 32*w+b.
- R5: Clearing the mask of a pending vector emits its message and clears its pending flag.
- R6: While `fnMask` is 1, no message starts, and the pending flags are kept and can still be set by requests. Releasing the hold emits the eligible messages.
- R7: When several vectors are eligible, they are served one per accepted message, in ascending circular order starting after the most recently served vector.
- R8: While `msgValid` is 1 and `msgReady` is 0, `msgValid`, `msgAddr` and `msgData` stay unchanged.
- R9: A request whose index is not below the table size changes no pending flag and emits nothing. It raises `irqErr` for exactly the cycle after it is sampled.
- R10: While `dataWrIdle` is 0 (an earlier data write is outstanding), no message starts. This keeps an interrupt write from overtaking a prior data write.
- R11: While `fnEnable` is 0, requests are dropped (no pending flag is set) and no message starts.
- R12: Writes to the pending region are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | $clog2(NUM_VEC)+3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| irqValid | input | 1 | Interrupt request strobe |
| irqIdx | input | REQ_W | Requested vector number |
| irqErr | output | 1 | One-cycle pulse after an out-of-range request |
| fnEnable | input | 1 | Function enable |
| fnMask | input | 1 | Function-wide hold of all messages |
| dataWrIdle | input | 1 | High when no earlier data write is outstanding |
| msgValid | output | 1 | Message write valid |
| msgReady | input | 1 | Message write accepted |
| msgAddr | output | 64 | Message target address |
| msgData | output | 32 | Message payload |

## Verification
The main function is exercised with four patterns:
- A single unmasked request shows the two-edge latency and the address/payload lookup.
- A request on a masked vector followed by an unmask separates "pending then emitted on unmask" from "emitted at once".
- Three vectors made eligible together while the function-wide hold is set, and then released, show that the rotation starts after the last served vector rather than at vector 0.
- Requests made while the output is stalled, while a data write is outstanding, while the function is disabled, or with an index beyond the table separate holding a message, delaying it, dropping it and flagging it as an error.

// File: rtl/vmg_pkg.sv
package vmg_pkg;
  localparam int MAX_VEC_W = 11;

  // strobes from the control to the datapath
  typedef struct packed {
    logic                 load;  // capture the table row of idx into the message register
    logic [MAX_VEC_W-1:0] idx;
  } vmgStrobe_t;
endpackage

// File: rtl/vmg_datapath.sv
module vmg_datapath
  import vmg_pkg::*;
#(
  parameter int NUM_VEC    = 16,
  parameter int VEC_W      = 4,
  parameter int RA_W       = 7,
  parameter int PEND_WORDS = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic [RA_W-1:0]         regAddr,
  input  logic [31:0]             regWrData,
  output logic [31:0]             regRdData,
  input  logic [PEND_WORDS*32-1:0] pendVec,
  output logic [NUM_VEC-1:0]      maskVec,
  input  vmgStrobe_t              stb,
  input  logic                    msgReady,
  output logic                    msgValid,
  output logic [63:0]             msgAddr,
  output logic [31:0]             msgData
);
  logic [31:0] addrLo [NUM_VEC];
  logic [31:0] addrHi [NUM_VEC];
  logic [31:0] payload[NUM_VEC];
  logic        maskQ  [NUM_VEC];

  logic             isPend;
  logic [VEC_W-1:0] vecSel;
  logic [1:0]       wordSel;
  logic [VEC_W+1:0] pendWordSel;

  assign isPend      = regAddr[RA_W-1];
  assign vecSel      = regAddr[VEC_W+1:2];
  assign wordSel     = regAddr[1:0];
  assign pendWordSel = regAddr[VEC_W+1:0];

  // table storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        addrLo[v]  <= '0;
        addrHi[v]  <= '0;
        payload[v] <= '0;
        maskQ[v]   <= 1'b1;
      end
    end else if (regWrEn && !isPend) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (int'(vecSel) == v) begin
          case (wordSel)
            2'd0:    addrLo[v]  <= regWrData;
            2'd1:    addrHi[v]  <= regWrData;
            2'd2:    payload[v] <= regWrData;
            default: maskQ[v]   <= regWrData[0];
          endcase
        end
      end
    end
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_mask
    assign maskVec[v] = maskQ[v];
  end

  // register read mux
  always_comb begin
    regRdData = '0;
    if (isPend) begin
      for (int w = 0; w < PEND_WORDS; w++) begin
        if (int'(pendWordSel) == w) regRdData = pendVec[w*32 +: 32];
      end
    end else begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (int'(vecSel) == v) begin
          case (wordSel)
            2'd0:    regRdData = addrLo[v];
            2'd1:    regRdData = addrHi[v];
            2'd2:    regRdData = payload[v];
            default: regRdData = {31'd0, maskQ[v]};
          endcase
        end
      end
    end
  end

  // row lookup for the granted vector
  logic [63:0] selAddr;
  logic [31:0] selData;
  always_comb begin
    selAddr = '0;
    selData = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (int'(stb.idx) == v) begin
        selAddr = {addrHi[v], addrLo[v]};
        selData = payload[v];
      end
    end
  end

  // message output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgValid <= 1'b0;
      msgAddr  <= '0;
      msgData  <= '0;
    end else if (stb.load) begin
      msgValid <= 1'b1;
      msgAddr  <= selAddr;
      msgData  <= selData;
    end else if (msgReady) begin
      msgValid <= 1'b0;
    end
  end
endmodule

// File: rtl/vmg_control.sv
module vmg_control
  import vmg_pkg::*;
#(
  parameter int NUM_VEC    = 16,
  parameter int VEC_W      = 4,
  parameter int REQ_W      = 11,
  parameter int PEND_WORDS = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     irqValid,
  input  logic [REQ_W-1:0]         irqIdx,
  input  logic                     fnEnable,
  input  logic                     fnMask,
  input  logic                     dataWrIdle,
  input  logic [NUM_VEC-1:0]       maskVec,
  input  logic                     msgValid,
  input  logic                     msgReady,
  output logic [PEND_WORDS*32-1:0] pendVec,
  output vmgStrobe_t               stb,
  output logic                     irqErr
);
  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] reqHit;
  logic [NUM_VEC-1:0] grantClr;
  logic [NUM_VEC-1:0] elig;
  logic [VEC_W-1:0]   lastPtr;
  logic [VEC_W-1:0]   gIdx;
  logic               found;
  logic               canIssue;
  logic               inRange;

  assign inRange = int'(irqIdx) < NUM_VEC;

  // decode the request into a one-hot set mask
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_req
    assign reqHit[v]   = irqValid && fnEnable && (int'(irqIdx) == v);
    assign grantClr[v] = stb.load && (int'(gIdx) == v);
  end

  assign elig     = pend & ~maskVec;
  assign canIssue = fnEnable && !fnMask && dataWrIdle && (!msgValid || msgReady);

  // rotating priority: first eligible vector after lastPtr
  always_comb begin
    int j;
    found = 1'b0;
    gIdx  = '0;
    for (int i = 1; i <= NUM_VEC; i++) begin
      j = (int'(lastPtr) + i) % NUM_VEC;
      if (!found && elig[j]) begin
        found = 1'b1;
        gIdx  = j[VEC_W-1:0];
      end
    end
  end

  always_comb begin
    stb.load = canIssue && found;
    stb.idx  = MAX_VEC_W'(gIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend    <= '0;
      lastPtr <= VEC_W'(NUM_VEC - 1);
      irqErr  <= 1'b0;
    end else begin
      pend   <= (pend & ~grantClr) | reqHit;
      irqErr <= irqValid && !inRange;
      if (stb.load) lastPtr <= gIdx;
    end
  end

  always_comb begin
    pendVec = '0;
    pendVec[NUM_VEC-1:0] = pend;
  end
endmodule

// File: rtl/vec_msg_gen.sv
module vec_msg_gen
  import vmg_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int REQ_W   = 11,
  localparam int VEC_W      = $clog2(NUM_VEC),
  localparam int RA_W       = VEC_W + 3,
  localparam int PEND_WORDS = (NUM_VEC + 31) / 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [RA_W-1:0]  regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             irqValid,
  input  logic [REQ_W-1:0] irqIdx,
  output logic             irqErr,
  input  logic             fnEnable,
  input  logic             fnMask,
  input  logic             dataWrIdle,
  output logic             msgValid,
  input  logic             msgReady,
  output logic [63:0]      msgAddr,
  output logic [31:0]      msgData
);
  vmgStrobe_t                stb;
  logic [PEND_WORDS*32-1:0]  pendVec;
  logic [NUM_VEC-1:0]        maskVec;

  vmg_control #(
    .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .REQ_W(REQ_W), .PEND_WORDS(PEND_WORDS)
  ) uCtl (
    .clk(clk), .rstN(rstN), .irqValid(irqValid), .irqIdx(irqIdx),
    .fnEnable(fnEnable), .fnMask(fnMask), .dataWrIdle(dataWrIdle),
    .maskVec(maskVec), .msgValid(msgValid), .msgReady(msgReady),
    .pendVec(pendVec), .stb(stb), .irqErr(irqErr)
  );

  vmg_datapath #(
    .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .RA_W(RA_W), .PEND_WORDS(PEND_WORDS)
  ) uDp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pendVec(pendVec),
    .maskVec(maskVec), .stb(stb), .msgReady(msgReady), .msgValid(msgValid),
    .msgAddr(msgAddr), .msgData(msgData)
  );
endmodule

// File: rtl/vec_msg_gen_chk.sv
module vec_msg_gen_chk #(
  parameter int NUM_VEC    = 16,
  parameter int REQ_W      = 11,
  parameter int PEND_WORDS = 1
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     irqValid,
  input logic [REQ_W-1:0]         irqIdx,
  input logic                     irqErr,
  input logic                     fnEnable,
  input logic                     fnMask,
  input logic                     dataWrIdle,
  input logic                     msgValid,
  input logic                     msgReady,
  input logic [63:0]              msgAddr,
  input logic [31:0]              msgData,
  input logic                     stbLoad,
  input logic [10:0]              stbIdx,
  input logic [PEND_WORDS*32-1:0] pendVec
);
  // R8
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid && $stable(msgAddr) && $stable(msgData));

  // R6 R10 R11
  msg_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgValid) |-> $past(fnEnable && !fnMask && dataWrIdle));

  // R9
  err_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqErr |-> $past(irqValid && (int'(irqIdx) >= NUM_VEC)));

  // R3
  load_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    stbLoad |=> msgValid);

  // R5
  grant_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    stbLoad |-> (int'(stbIdx) < NUM_VEC) && pendVec[stbIdx]);
endmodule

bind vec_msg_gen vec_msg_gen_chk #(
  .NUM_VEC(NUM_VEC), .REQ_W(REQ_W), .PEND_WORDS(PEND_WORDS)
) uChk (
  .clk(clk), .rstN(rstN), .irqValid(irqValid), .irqIdx(irqIdx), .irqErr(irqErr),
  .fnEnable(fnEnable), .fnMask(fnMask), .dataWrIdle(dataWrIdle),
  .msgValid(msgValid), .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData),
  .stbLoad(stb.load), .stbIdx(stb.idx), .pendVec(pendVec)
);

// File: tb/vec_msg_gen_test.sv
`timescale 1ns/1ps
module vec_msg_gen_test;
  localparam int NV        = 16;
  localparam int RQW       = 11;
  localparam int VW        = $clog2(NV);
  localparam int RAW       = VW + 3;
  localparam int PEND_BASE = 1 << (VW + 2);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            regWrEn = 1'b0;
  logic [RAW-1:0]  regAddr = '0;
  logic [31:0]     regWrData = '0;
  logic [31:0]     regRdData;
  logic            irqValid = 1'b0;
  logic [RQW-1:0]  irqIdx = '0;
  logic            irqErr;
  logic            fnEnable = 1'b1;
  logic            fnMask = 1'b0;
  logic            dataWrIdle = 1'b1;
  logic            msgValid;
  logic            msgReady = 1'b1;
  logic [63:0]     msgAddr;
  logic [31:0]     msgData;

  always #2.5 clk = ~clk;

  vec_msg_gen #(.NUM_VEC(NV), .REQ_W(RQW)) uut (.*);

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [95:0] expQ[$];

  function automatic logic [31:0] loOf(int v);  return 32'hA000_0000 + 32'(v * 16); endfunction
  function automatic logic [31:0] hiOf(int v);  return 32'h0000_00F0 + 32'(v); endfunction
  function automatic logic [31:0] datOf(int v); return 32'hD000_0000 + 32'(v); endfunction
  function automatic logic [95:0] itemOf(int v); return {hiOf(v), loOf(v), datOf(v)}; endfunction
  function automatic logic [RAW-1:0] tAddr(int v, int k); return RAW'(v * 4 + k); endfunction

  task automatic check(bit ok, string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [RAW-1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [RAW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic request(int v);
    @(negedge clk);
    irqValid = 1'b1; irqIdx = RQW'(v);
    @(negedge clk);
    irqValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each accepted message against the scoreboard queue
  always begin
    @(negedge clk);
    #1;
    if (rstN && msgValid && msgReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3 unexpected message", {msgAddr, msgData}, '0);
      end else begin
        logic [95:0] e;
        e = expQ.pop_front();
        check({msgAddr, msgData} == e, "R3/R7 message content/order", {msgAddr, msgData}, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog", '0, '0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] heldAddr;

    idle(3);
    rstN = 1'b1;

    // R1: reset state
    regRead(tAddr(0, 3), rd);  check(rd == 32'd1, "R1 mask after reset", 96'(rd), 96'd1);
    regRead(tAddr(15, 0), rd); check(rd == 32'd0, "R1 address after reset", 96'(rd), 96'd0);
    regRead(RAW'(PEND_BASE), rd); check(rd == 32'd0, "R1 pending after reset", 96'(rd), 96'd0);
    #1 check(msgValid == 1'b0 && irqErr == 1'b0, "R1 outputs idle", {94'd0, msgValid, irqErr}, '0);

    // R2: program every row and read some back
    for (int v = 0; v < NV; v++) begin
      regWrite(tAddr(v, 0), loOf(v));
      regWrite(tAddr(v, 1), hiOf(v));
      regWrite(tAddr(v, 2), datOf(v));
    end
    regRead(tAddr(5, 0), rd); check(rd == loOf(5), "R2 low address readback", 96'(rd), 96'(loOf(5)));
    regRead(tAddr(5, 1), rd); check(rd == hiOf(5), "R2 high address readback", 96'(rd), 96'(hiOf(5)));
    regRead(tAddr(5, 2), rd); check(rd == datOf(5), "R2 payload readback", 96'(rd), 96'(datOf(5)));
    regWrite(tAddr(3, 3), 32'hFFFF_FFFE);
    regRead(tAddr(3, 3), rd); check(rd == 32'd0, "R2 control word only bit 0", 96'(rd), 96'd0);

    // R3: single unmasked request, latency two edges
    expQ.push_back(itemOf(3));
    request(3);
    #1 check(msgValid == 1'b0, "R3 not yet valid after one edge", 96'(msgValid), 96'd0);
    @(negedge clk);
    #1 check(msgValid == 1'b1 && msgAddr == {hiOf(3), loOf(3)}, "R3 valid with row address",
             {31'd0, msgValid, msgAddr}, {32'd1, hiOf(3), loOf(3)});
    idle(3);

    // R4 then R5: masked request pends, unmask emits
    request(6);
    idle(3);
    regRead(RAW'(PEND_BASE), rd); check(rd == 32'h40, "R4 pending bit of masked vector", 96'(rd), 96'h40);
    #1 check(msgValid == 1'b0, "R4 no message while masked", 96'(msgValid), 96'd0);
    expQ.push_back(itemOf(6));
    regWrite(tAddr(6, 3), 32'd0);
    idle(3);
    regRead(RAW'(PEND_BASE), rd); check(rd == 32'd0, "R5 pending cleared after unmask", 96'(rd), 96'd0);
    check(expQ.size() == 0, "R5 message emitted on unmask", 96'(expQ.size()), 96'd0);

    // R6 and R7: three pending vectors released together, rotation after vector 6
    request(2); request(5); request(9);
    fnMask = 1'b1;
    regWrite(tAddr(2, 3), 32'd0);
    regWrite(tAddr(5, 3), 32'd0);
    regWrite(tAddr(9, 3), 32'd0);
    idle(3);
    regRead(RAW'(PEND_BASE), rd);
    check(rd == 32'h0224, "R6 pending kept under function hold", 96'(rd), 96'h0224);
    #1 check(msgValid == 1'b0, "R6 no message under function hold", 96'(msgValid), 96'd0);
    expQ.push_back(itemOf(9));
    expQ.push_back(itemOf(2));
    expQ.push_back(itemOf(5));
    @(negedge clk); fnMask = 1'b0;
    idle(8);
    check(expQ.size() == 0, "R7 all three served", 96'(expQ.size()), 96'd0);
    regRead(RAW'(PEND_BASE), rd); check(rd == 32'd0, "R7 pending drained", 96'(rd), 96'd0);

    // R8: stalled message stays stable
    @(negedge clk); msgReady = 1'b0;
    expQ.push_back(itemOf(3));
    request(3);
    @(negedge clk);
    #1 heldAddr = msgAddr;
    check(msgValid == 1'b1, "R8 valid while stalled", 96'(msgValid), 96'd1);
    idle(4);
    #1 check(msgValid == 1'b1 && msgAddr == heldAddr, "R8 held stable",
             {31'd0, msgValid, msgAddr}, {32'd1, heldAddr});
    @(negedge clk); msgReady = 1'b1;
    idle(3);
    check(expQ.size() == 0, "R8 delivered after ready", 96'(expQ.size()), 96'd0);

    // R10: outstanding data write holds off the message
    @(negedge clk); dataWrIdle = 1'b0;
    expQ.push_back(itemOf(2));
    request(2);
    idle(5);
    #1 check(msgValid == 1'b0, "R10 held while data write outstanding", 96'(msgValid), 96'd0);
    @(negedge clk); dataWrIdle = 1'b1;
    idle(4);
    check(expQ.size() == 0, "R10 emitted after data write done", 96'(expQ.size()), 96'd0);

    // R11: disabled function drops requests
    @(negedge clk); fnEnable = 1'b0;
    request(3);
    idle(3);
    regRead(RAW'(PEND_BASE), rd); check(rd == 32'd0, "R11 no pending while disabled", 96'(rd), 96'd0);
    #1 check(msgValid == 1'b0, "R11 no message while disabled", 96'(msgValid), 96'd0);
    @(negedge clk); fnEnable = 1'b1;
    idle(4);
    #1 check(msgValid == 1'b0, "R11 dropped request not replayed", 96'(msgValid), 96'd0);

    // R9: out-of-range index
    request(20);
    #1 check(irqErr == 1'b1, "R9 error pulse", 96'(irqErr), 96'd1);
    @(negedge clk);
    #1 check(irqErr == 1'b0, "R9 error lasts one cycle", 96'(irqErr), 96'd0);
    regRead(RAW'(PEND_BASE), rd); check(rd == 32'd0, "R9 no pending set", 96'(rd), 96'd0);

    // R12: pending region is read-only
    regWrite(RAW'(PEND_BASE), 32'h0000_FFFF);
    regRead(RAW'(PEND_BASE), rd); check(rd == 32'd0, "R12 pending write ignored", 96'(rd), 96'd0);
    idle(3);
    #1 check(msgValid == 1'b0, "R12 no message from pending write", 96'(msgValid), 96'd0);

    idle(5);
    check(expQ.size() == 0, "R3 scoreboard empty at end", 96'(expQ.size()), 96'd0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule